// File: doc/BRIEF.md
# IDE Multiword DMA Handshake Timer

This block runs the strobe side of a multiword DMA burst to an IDE device. It counts everything in PCI clocks. When the bus-master function is engaged and the device raises its DMA request, the block asserts DMA acknowledge. It then drives the read strobe or the write strobe once for each data word, with a strobe-active time and a recovery time taken from a programmable timing set. On the clock where a strobe goes inactive, the block samples the device's request. If the request is still present, another word follows after the recovery time. If the request is gone, acknowledge is released on the next clock, and the block waits until the device asks again.

Two timing sets are supplied. One is the PIO set, which DMA cycles use by default. The other is a faster set that a DMA-only enable selects for DMA cycles; PIO cycles elsewhere keep the slower set. Every count of zero is treated as one clock. The block moves no data. A one-clock word pulse after each strobe tells a neighbouring buffer when to capture or supply a word.

Top module: `ide_dma_hs_ctrl`

## Requirements
- R1: While reset is held and on the first clock after it, dev_dack, rd_strobe, wr_strobe and word_pulse are all 0.
- R2: From idle, an edge that sees run_en=1 and dev_dreq=1 raises dev_dack. The first strobe rises exactly one clock later.
- R3: Each strobe stays high for the active count of the selected set. The set is dma_act_clks when dma_timing_only=1 and pio_act_clks when dma_timing_only=0. A count of 0 gives 1 clock.
- R4: Between two strobes of one burst, both strobes stay low for the recovery count of the selected set (dma_rec_clks or pio_rec_clks, chosen the same way). A count of 0 gives 1 clock.
- R5: dev_dreq is sampled on the edge where a strobe goes low. If it is 1, dev_dack stays high and another strobe follows after the recovery time.
- R6: If dev_dreq is 0 at that sample, dev_dack stays high for exactly one more clock with no strobe, and then drops.
- R7: dev_dack never rises unless the edge before saw dev_dreq=1 and run_en=1. With run_en=0, a held request gets no acknowledge.
- R8: word_pulse is high for exactly one clock: the first clock after each strobe's last high clock. It is never high at any other time.
- R9: dir_wr=1 selects wr_strobe and dir_wr=0 selects rd_strobe. The value is taken on the edge that raises dev_dack and holds for the whole burst. rd_strobe and wr_strobe are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Bus-master engine started; permits new bursts |
| dir_wr | input | 1 | 1 = memory-to-device (write strobe), 0 = device-to-memory |
| dma_timing_only | input | 1 | 1 = DMA cycles use the fast set |
| pio_act_clks | input | CNT_W | PIO set strobe-active clocks |
| pio_rec_clks | input | CNT_W | PIO set recovery clocks |
| dma_act_clks | input | CNT_W | Fast set strobe-active clocks |
| dma_rec_clks | input | CNT_W | Fast set recovery clocks |
| dev_dreq | input | 1 | Device DMA request |
| dev_dack | output | 1 | DMA acknowledge to device |
| rd_strobe | output | 1 | Read strobe (active high) |
| wr_strobe | output | 1 | Write strobe (active high) |
| word_pulse | output | 1 | One-clock marker per completed word |

## Verification
The hardest case to reach is the request moving on the exact clock where a strobe falls. The request may drop just then, or drop during recovery and come back before the next sample; an acknowledge release timed one clock off shows up only in these windows. The stimulus redraws dev_dreq every clock with a bias toward staying high, and it draws short timing counts, zero included. This puts many strobe falls under both request levels. Directed bursts add a single-word burst and a held request with run_en low. The direction input also toggles mid-burst, which shows whether the burst-start value is kept.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ACK    = 3'd1,
    PH_STROBE = 3'd2,
    PH_RECOV  = 3'd3,
    PH_END    = 3'd4
  } phase_e;
endpackage

// File: rtl/ide_dma_tsel.sv
module ide_dma_tsel #(
  parameter int CNT_W = 4
) (
  input  logic             fast_sel,
  input  logic [CNT_W-1:0] slow_act,
  input  logic [CNT_W-1:0] slow_rec,
  input  logic [CNT_W-1:0] fast_act,
  input  logic [CNT_W-1:0] fast_rec,
  output logic [CNT_W-1:0] act_clks,
  output logic [CNT_W-1:0] rec_clks
);
  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  always_comb begin
    act_clks = at_least_one(fast_sel ? fast_act : slow_act);
    rec_clks = at_least_one(fast_sel ? fast_rec : slow_rec);
  end
endmodule

// File: rtl/ide_dma_cnt.sv
module ide_dma_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/ide_dma_hs_ctrl.sv
module ide_dma_hs_ctrl
  import ide_dma_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             dir_wr,
  input  logic             dma_timing_only,
  input  logic [CNT_W-1:0] pio_act_clks,
  input  logic [CNT_W-1:0] pio_rec_clks,
  input  logic [CNT_W-1:0] dma_act_clks,
  input  logic [CNT_W-1:0] dma_rec_clks,
  input  logic             dev_dreq,
  output logic             dev_dack,
  output logic             rd_strobe,
  output logic             wr_strobe,
  output logic             word_pulse
);
  phase_e           phase_q, phase_d;
  logic             dir_q;
  logic [CNT_W-1:0] act_q, rec_q;
  logic [CNT_W-1:0] sel_act, sel_rec;
  logic             cnt_load, cnt_done;
  logic [CNT_W-1:0] cnt_val;
  logic             word_q;

  // named internal events
  logic burst_go;     // idle and device asks
  logic sample_evt;   // last strobe clock: request sampled at its closing edge
  logic recov_done;

  ide_dma_tsel #(.CNT_W(CNT_W)) u_tsel (
    .fast_sel (dma_timing_only),
    .slow_act (pio_act_clks),
    .slow_rec (pio_rec_clks),
    .fast_act (dma_act_clks),
    .fast_rec (dma_rec_clks),
    .act_clks (sel_act),
    .rec_clks (sel_rec)
  );

  ide_dma_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .done     (cnt_done)
  );

  assign burst_go   = (phase_q == PH_IDLE) && run_en && dev_dreq;
  assign sample_evt = (phase_q == PH_STROBE) && cnt_done;
  assign recov_done = (phase_q == PH_RECOV) && cnt_done;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (burst_go) phase_d = PH_ACK;
      PH_ACK:    phase_d = PH_STROBE;
      PH_STROBE: if (sample_evt) phase_d = dev_dreq ? PH_RECOV : PH_END;
      PH_RECOV:  if (recov_done) phase_d = PH_STROBE;
      PH_END:    phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  // counter holds (clocks - 1) for the phase being entered
  assign cnt_load = (phase_q == PH_ACK) || recov_done || (sample_evt && dev_dreq);
  assign cnt_val  = (sample_evt ? rec_q : act_q) - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      dir_q   <= 1'b0;
      act_q   <= CNT_W'(1);
      rec_q   <= CNT_W'(1);
      word_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      word_q  <= sample_evt;
      if (burst_go) begin
        dir_q <= dir_wr;
        act_q <= sel_act;
        rec_q <= sel_rec;
      end
    end
  end

  assign dev_dack   = (phase_q != PH_IDLE);
  assign rd_strobe  = (phase_q == PH_STROBE) && !dir_q;
  assign wr_strobe  = (phase_q == PH_STROBE) &&  dir_q;
  assign word_pulse = word_q;

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe)); // R9
  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_dack) |-> $past(dev_dreq) && $past(run_en)); // R7
  AST_KEEP_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && dev_dreq) |=> dev_dack); // R5
  AST_DROP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && !dev_dreq) |=> (dev_dack && !rd_strobe && !wr_strobe) ##1 !dev_dack); // R6
  AST_WORD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    word_pulse |-> !(rd_strobe || wr_strobe) && $past(rd_strobe || wr_strobe)); // R8
  AST_FIRST_STB_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_dack) |=> (rd_strobe || wr_strobe)); // R2
endmodule

// File: tb/ide_dma_hs_ctrl_tb_top.sv
module ide_dma_hs_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, dir_wr = 1'b0, dma_timing_only = 1'b0, dev_dreq = 1'b0;
  logic [CNT_W-1:0] pio_act_clks = 4'd3, pio_rec_clks = 4'd2;
  logic [CNT_W-1:0] dma_act_clks = 4'd1, dma_rec_clks = 4'd1;
  logic dev_dack, rd_strobe, wr_strobe, word_pulse;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_dma_hs_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .dir_wr(dir_wr),
    .dma_timing_only(dma_timing_only),
    .pio_act_clks(pio_act_clks), .pio_rec_clks(pio_rec_clks),
    .dma_act_clks(dma_act_clks), .dma_rec_clks(dma_rec_clks),
    .dev_dreq(dev_dreq), .dev_dack(dev_dack), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .word_pulse(word_pulse)
  );

  function automatic int want_clks(input bit fast, input int slow_v, input int fast_v);
    int v;
    v = fast ? fast_v : slow_v;
    if (v < 1) v = 1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor state
  bit p_stb = 0, p_dack = 0, first_stb = 0, expect_drop = 0, burst_dir = 0;
  int hi_len = 0, gap = 0;

  // sample outputs at negedge; inputs still hold what the last posedge saw
  task automatic step();
    bit stb;
    int e_act, e_rec;
    @(negedge clk);
    if (!rst_n) return;
    stb   = rd_strobe | wr_strobe;
    e_act = want_clks(dma_timing_only, pio_act_clks, dma_act_clks);
    e_rec = want_clks(dma_timing_only, pio_rec_clks, dma_rec_clks);
    if (rd_strobe && wr_strobe) chk(0, "R9 both strobes", 1, 0);
    if (expect_drop) begin
      chk(!dev_dack && !stb, "R6 dack release", dev_dack, 0);
      expect_drop = 0;
    end else if (p_dack && !dev_dack) begin
      chk(0, "R5 unexpected dack drop", 0, 1);
    end
    if (dev_dack && !p_dack) begin
      chk(run_en && dev_dreq, "R7 dack start cause", run_en & dev_dreq, 1);
      chk(!stb, "R2 no strobe with dack rise", stb, 0);
      burst_dir = dir_wr; first_stb = 1; gap = 0;
    end
    if (stb && !p_stb) begin
      if (first_stb) chk(gap == 1, "R2 ack-to-strobe", gap, 1);
      else           chk(gap == e_rec, "R4 recovery", gap, e_rec);
      first_stb = 0;
    end
    if (stb) begin
      chk(wr_strobe == burst_dir, "R9 direction", wr_strobe, burst_dir);
      hi_len = p_stb ? hi_len + 1 : 1;
    end
    if (p_stb && !stb) begin
      chk(hi_len == e_act, "R3 strobe width", hi_len, e_act);
      chk(word_pulse, "R8 word pulse", word_pulse, 1);
      chk(dev_dack, "R5 dack held at sample", dev_dack, 1);
      gap = 0;
      if (!dev_dreq) expect_drop = 1;
    end else if (word_pulse) begin
      chk(0, "R8 stray word pulse", 1, 0);
    end
    if (!stb) gap++;
    p_stb = stb; p_dack = dev_dack;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1DE0));
    // R1: reset
    repeat (3) @(negedge clk);
    chk(!dev_dack && !rd_strobe && !wr_strobe && !word_pulse, "R1 reset outputs", dev_dack, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dev_dack && !rd_strobe && !wr_strobe && !word_pulse, "R1 after reset", dev_dack, 0);

    // R7: held request, engine off
    dev_dreq = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step();
      chk(!dev_dack, "R7 no ack when run_en low", dev_dack, 0);
    end
    dev_dreq = 1'b0;
    step();

    // R6: single-word burst, PIO set 3/2
    run_en = 1'b1; dir_wr = 1'b0; dev_dreq = 1'b1;
    step();
    dev_dreq = 1'b0;
    for (int i = 0; i < 10; i++) step();
    chk(!dev_dack, "R6 single word ends idle", dev_dack, 0);

    // R3/R4: zero counts clamp to one, PIO set
    pio_act_clks = 4'd0; pio_rec_clks = 4'd0; dir_wr = 1'b1; dev_dreq = 1'b1;
    for (int i = 0; i < 12; i++) step();
    dev_dreq = 1'b0;
    for (int i = 0; i < 6; i++) step();

    // R3/R4: fast set selected for DMA
    pio_act_clks = 4'd6; pio_rec_clks = 4'd5;
    dma_act_clks = 4'd2; dma_rec_clks = 4'd1; dma_timing_only = 1'b1;
    dev_dreq = 1'b1;
    for (int i = 0; i < 15; i++) step();
    dev_dreq = 1'b0;
    for (int i = 0; i < 8; i++) step();
    dma_timing_only = 1'b0;
    dev_dreq = 1'b1;
    for (int i = 0; i < 30; i++) step();
    dev_dreq = 1'b0;
    for (int i = 0; i < 15; i++) step();

    // random mix
    for (int i = 0; i < 6000; i++) begin
      step();
      if (!dev_dack && ($urandom % 4 == 0)) begin
        pio_act_clks    = CNT_W'($urandom % 6);
        pio_rec_clks    = CNT_W'($urandom % 6);
        dma_act_clks    = CNT_W'($urandom % 4);
        dma_rec_clks    = CNT_W'($urandom % 4);
        dma_timing_only = 1'($urandom % 2);
      end
      dev_dreq = ($urandom % 10) < 7;
      run_en   = ($urandom % 16) != 0;
      if ($urandom % 8 == 0) dir_wr = ~dir_wr;
    end
    dev_dreq = 1'b0;
    for (int i = 0; i < 30; i++) step();
    chk(!dev_dack, "R6 idle at end", dev_dack, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule